// File: doc/BRIEF.md
# Prescaled Programmable Rate Timer

This block is an 8-bit counter that counts up from a programmable start value. It is paced by a slow oscillator, which reaches the block as a one-cycle enable strobe (`osc_tick`). The strobe first passes through a shared binary divider. A two-bit field picks one of four divide ratios, and the counter advances on each divided strobe. When the counter steps past 0xFF it reloads the last value software wrote to it and raises a one-cycle overflow interrupt. The counter register therefore sets both the current count and the reload point.

The same divider also produces a slow periodic tick at the oscillator rate divided by 2^TICK_LOG2, which defaults to 2^19 and gives about one pulse per second. This tick raises its own interrupt, and it keeps running whether or not the counter is enabled. One control byte holds all the settings: the rate select, the count enable, the tick enable, an oscillator gate, a master mask over both interrupts, and a display-enable bit. The display-enable bit is only stored and read back. Software reaches the two registers over a byte-wide bus. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `rate_timer`

## Requirements
- R1: After reset the control register (address 0) and the counter register (address 1) both read 0x00, and `ovf_irq` and `tick_irq` are low.
- R2: The control byte has these fields: bit 7 is the interrupt mask, bits 5:4 are the rate code, bit 3 is the count enable, bit 2 is the tick enable, bit 1 is the oscillator enable and bit 0 is the display enable. Bit 6 always reads 0, so writing 0xFF reads back 0xBF.
- R3: A write to address 1 sets both the count and the reload value from the next cycle on. Reading address 1 returns the current count.
- R4: With rate code k, the counter advances once per 2^RATEk_LOG2 qualified oscillator strobes. Each control write restarts the divider from zero. With a strobe every cycle and start value V, the first wrap occurs (256−V)·2^RATEk_LOG2 cycles after the control write.
- R5: A step from 0xFF loads the reload value into the counter and pulses `ovf_irq` high for exactly one cycle. Later wraps repeat at the same interval.
- R6: While bit 3 is clear the count holds, but the divider and the tick keep running.
- R7: While bit 1 is clear, or while `osc_tick` is low, the divider, the counter and the tick do not advance. Once strobes resume they continue from where they stopped.
- R8: With bits 2 and 1 set, `tick_irq` pulses once every 2^TICK_LOG2 qualified strobes after the last control write, independent of bit 3.
- R9: While bit 7 is set neither interrupt output goes high. The counter still wraps and reloads.
- R10: Bit 0 is stored and read back but has no effect on counting, on wrap timing or on the interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe from the slow oscillator |
| reg_addr | input | 1 | Register select: 0 is control, 1 is counter |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the addressed register |
| ovf_irq | output | 1 | One-cycle pulse on counter wrap |
| tick_irq | output | 1 | One-cycle periodic tick pulse |

## Verification
A register write is visible on `rd_data` one clock edge after the write strobe is sampled. Both interrupt pulses are registered, so each rises on the same edge at which the divider and the counter make the step that causes it. Counted from the edge that captures a control write, and with `osc_tick` held high, the first overflow arrives at edge (256−V)·2^RATEk_LOG2 and the tick arrives at edge 2^TICK_LOG2. The bench counts rising edges from the write edge and samples the outputs at the falling edge after each one, so every due cycle is matched exactly rather than within a window. It uses small divider exponents so that these intervals stay short.

// File: rtl/rtp_pkg.sv
package rtp_pkg;

  typedef struct packed {
    logic       irq_mask;
    logic       rsvd;
    logic [1:0] rate;
    logic       cnt_en;
    logic       tick_en;
    logic       osc_en;
    logic       disp_en;
  } rtp_ctrl_t;

  localparam logic       ADDR_CTRL  = 1'b0;
  localparam logic       ADDR_CNT   = 1'b1;
  localparam logic [7:0] CTRL_WMASK = 8'hBF;

endpackage

// File: rtl/rtp_divider.sv
module rtp_divider #(
  parameter int RATE0_LOG2 = 5,
  parameter int RATE1_LOG2 = 9,
  parameter int RATE2_LOG2 = 12,
  parameter int RATE3_LOG2 = 18,
  parameter int TICK_LOG2  = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       adv,
  input  logic [1:0] rate_sel,
  output logic       step,
  output logic       tick
);

  localparam int RL [4] = '{RATE0_LOG2, RATE1_LOG2, RATE2_LOG2, RATE3_LOG2};
  localparam int M01 = (RATE0_LOG2 > RATE1_LOG2) ? RATE0_LOG2 : RATE1_LOG2;
  localparam int M23 = (RATE2_LOG2 > RATE3_LOG2) ? RATE2_LOG2 : RATE3_LOG2;
  localparam int MR  = (M01 > M23) ? M01 : M23;
  localparam int PW  = (MR > TICK_LOG2) ? MR : TICK_LOG2;

  logic [PW-1:0] div_q, div_d;
  logic [3:0]    hit;
  logic          live;

  // terminal count of each divide ratio: all low bits set
  for (genvar g = 0; g < 4; g++) begin : g_rate
    assign hit[g] = &div_q[RL[g]-1:0];
  end

  assign live = adv & ~restart;
  assign step = live & hit[rate_sel];
  assign tick = live & (&div_q[TICK_LOG2-1:0]);

  always_comb begin
    div_d = div_q;
    if (restart)  div_d = '0;
    else if (adv) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/rtp_counter.sv
module rtp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         wrap
);

  logic [W-1:0] count_d, reload_d;

  assign wrap = step & ~load & (&count);

  always_comb begin
    count_d  = count;
    reload_d = reload;
    if (load) begin
      count_d  = load_val;
      reload_d = load_val;
    end else if (wrap) begin
      count_d = reload;
    end else if (step) begin
      count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      count  <= count_d;
      reload <= reload_d;
    end
  end

endmodule

// File: rtl/rate_timer.sv
module rate_timer
  import rtp_pkg::*;
#(
  parameter int RATE0_LOG2 = 5,
  parameter int RATE1_LOG2 = 9,
  parameter int RATE2_LOG2 = 12,
  parameter int RATE3_LOG2 = 18,
  parameter int TICK_LOG2  = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       reg_addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       ovf_irq,
  output logic       tick_irq
);

  rtp_ctrl_t  ctrl_q, ctrl_d;
  logic       ctrl_wr, cnt_wr;
  logic       adv, step_raw, step, tick_raw, wrap;
  logic [7:0] cnt_val, cnt_reload;
  logic       ovf_d, tick_d;

  assign ctrl_wr = wr_en & (reg_addr == ADDR_CTRL);
  assign cnt_wr  = wr_en & (reg_addr == ADDR_CNT);
  assign adv     = osc_tick & ctrl_q.osc_en;

  rtp_divider #(
    .RATE0_LOG2 (RATE0_LOG2),
    .RATE1_LOG2 (RATE1_LOG2),
    .RATE2_LOG2 (RATE2_LOG2),
    .RATE3_LOG2 (RATE3_LOG2),
    .TICK_LOG2  (TICK_LOG2)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ctrl_wr),
    .adv      (adv),
    .rate_sel (ctrl_q.rate),
    .step     (step_raw),
    .tick     (tick_raw)
  );

  assign step = step_raw & ctrl_q.cnt_en;

  rtp_counter #(.W(8)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (wr_data),
    .step     (step),
    .count    (cnt_val),
    .reload   (cnt_reload),
    .wrap     (wrap)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = rtp_ctrl_t'(wr_data & CTRL_WMASK);
    ovf_d  = wrap & ~ctrl_q.irq_mask;
    tick_d = tick_raw & ctrl_q.tick_en & ~ctrl_q.irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ovf_irq  <= 1'b0;
      tick_irq <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      ovf_irq  <= ovf_d;
      tick_irq <= tick_d;
    end
  end

  assign rd_data = (reg_addr == ADDR_CNT) ? cnt_val : ctrl_q;

endmodule

// File: rtl/rtp_checker.sv
module rtp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl,
  input logic [7:0] count,
  input logic [7:0] reload,
  input logic       ovf_irq,
  input logic       tick_irq
);

  logic cnt_wr;
  assign cnt_wr = wr_en & reg_addr;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wr_data)) && (reload == $past(wr_data))); // R3

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq); // R5

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> count == reload); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[3] && !cnt_wr) |=> $stable(count)); // R6

  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && !cnt_wr) |=> ($stable(count) && !tick_irq)); // R7

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> ($past(ctrl[2]) && $past(ctrl[1]))); // R8

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |=> (!ovf_irq && !tick_irq)); // R9

endmodule

bind rate_timer rtp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .ctrl     (ctrl_q),
  .count    (cnt_val),
  .reload   (cnt_reload),
  .ovf_irq  (ovf_irq),
  .tick_irq (tick_irq)
);

// File: tb/tb_rate_timer.sv
`timescale 1ns/1ps
module tb_rate_timer;

  localparam int R0 = 1, R1 = 2, R2 = 3, R3 = 4, TK = 8;
  localparam int TICK_PER = 1 << TK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       reg_addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ovf_irq, tick_irq;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rate_timer #(
    .RATE0_LOG2(R0), .RATE1_LOG2(R1), .RATE2_LOG2(R2), .RATE3_LOG2(R3), .TICK_LOG2(TK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ovf_irq(ovf_irq), .tick_irq(tick_irq)
  );

  // {control byte, start value, expected edges from control write to wrap}
  localparam logic [31:0] VEC [6] = '{
    {8'h0A, 8'hF0, 16'd32},
    {8'h1A, 8'h80, 16'd512},
    {8'h2A, 8'hFE, 16'd16},
    {8'h3A, 8'hC0, 16'd1024},
    {8'h0A, 8'hFF, 16'd2},
    {8'h0B, 8'hF0, 16'd32}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  // count rising edges until the chosen interrupt is seen at the following falling edge
  task automatic wait_irq(input bit use_tick, input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (use_tick ? tick_irq : ovf_irq) return;
    end
    n = -1;
  endtask

  // watch both interrupts over a window; returns number of cycles with either high
  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ovf_irq || tick_irq) hits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl", v, 8'h00);
    rd(1'b1, v); check("R1 count", v, 8'h00);
    check("R1 irqs", {ovf_irq, tick_irq}, 0);

    // R2 field layout, bit 6 reads zero
    wr(1'b0, 8'hFF); rd(1'b0, v); check("R2 readback", v, 8'hBF);
    wr(1'b0, 8'h00); rd(1'b0, v); check("R2 clear", v, 8'h00);

    // R3 counter load and read
    wr(1'b1, 8'h5A); rd(1'b1, v); check("R3 load", v, 8'h5A);

    // R4 R5 R10 rate table, two consecutive wraps each
    foreach (VEC[k]) begin
      wr(1'b0, 8'h00);
      wr(1'b1, VEC[k][23:16]);
      wr(1'b0, VEC[k][31:24]);
      wait_irq(1'b0, 4 * int'(VEC[k][15:0]) + 20, n);
      check(VEC[k][24] ? "R10 wrap time with bit0" : "R4 first wrap", n, int'(VEC[k][15:0]));
      rd(1'b1, v); check("R5 reload after wrap", v, VEC[k][23:16]);
      @(negedge clk); check("R5 single-cycle pulse", ovf_irq, 0);
      wait_irq(1'b0, 4 * int'(VEC[k][15:0]) + 20, n);
      check("R5 second wrap interval", n + 1, int'(VEC[k][15:0]));
    end

    // R6 R8 count disabled, tick still runs
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h06);
    wait_irq(1'b1, 2 * TICK_PER, n); check("R8 tick period", n, TICK_PER);
    rd(1'b1, v); check("R6 count held", v, 8'h10);
    @(negedge clk); check("R8 tick single pulse", tick_irq, 0);
    wait_irq(1'b1, 2 * TICK_PER, n); check("R8 second tick", n + 1, TICK_PER);

    // R7 oscillator disabled by bit 1
    wr(1'b0, 8'h0C);
    quiet(600, h); check("R7 osc off no irq", h, 0);
    rd(1'b1, v); check("R7 osc off count", v, 8'h10);

    // R7 strobe input held low, then resumed
    wr(1'b0, 8'h0E);
    osc_tick = 1'b0;
    quiet(600, h); check("R7 strobe low no irq", h, 0);
    rd(1'b1, v); check("R7 strobe low count", v, 8'h10);
    osc_tick = 1'b1;
    wait_irq(1'b1, 2 * TICK_PER, n); check("R7 resume tick", n, TICK_PER);
    rd(1'b1, v); check("R7 resume count", v, 8'h90);

    // R9 mask: no interrupts, counter still wraps and reloads
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h8E);
    quiet(31, h);
    rd(1'b1, v); check("R9 pre-wrap count", v, 8'hFF);
    quiet(1, n); h += n;
    rd(1'b1, v); check("R9 reload while masked", v, 8'hF0);
    quiet(300, n); h += n;
    check("R9 masked irqs", h, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule